// File: doc/BRIEF.md
# Transceiver Reset and Link Bring-Up Sequencer

This block takes an Ethernet transceiver from power-up to link-up without software. Once its own reset is released, it drives the transceiver's hardware reset pin low for a programmed number of milliseconds and then releases it. It then probes every management address in turn until a device answers with its control register out of reset. The address found is the one used for all later accesses.

When the found device already reports link, the block stops there. Otherwise it soft-resets the device and waits, with a bounded number of reads, for the reset bit to clear. It then turns on auto-negotiation with full duplex, restarts negotiation and polls link status at a fixed interval until link comes up or the wait budget runs out. Every register access goes through a request/acknowledge handshake to a separate serial management master. All waits are counted in milliseconds derived from the clock frequency, and a divider parameter shrinks them for simulation.

Top module: `phy_bringup_seq`

## Requirements
- R1: `phy_rst_no` is low during reset and stays low for at least RST_HOLD_MS milliseconds (RST_HOLD_MS × CLK_FREQ_HZ/1000/TIME_DIV cycles) after `rst_ni` rises. No management request is raised while it is low.
- R2: After the reset pin is released, register 0 is read at addresses 0, 1, 2 … in ascending order. The first address whose read data has bit 15 clear is selected and driven on `phy_addr_o`.
- R3: If no address from 0 to NUM_ADDR-1 has bit 15 clear, the block finishes with `done_o`=1, `fail_o`=1 (no device) and `link_up_o`=0.
- R4: The block then reads register 1 at the selected address. If bit 2 (link) is set, it finishes with `link_up_o`=1 and `fail_o`=0 and issues no write.
- R5: If link is down, the block writes register 0 with 16'h8000. It then reads register 0 until bit 15 reads clear, with at most SRST_TRIES reads.
- R6: If bit 15 is still set after SRST_TRIES reads, the block finishes with `fail_o`=2 (soft reset stuck).
- R7: After the soft reset clears, the block writes register 0 with 16'h1300 (bit 12 auto-negotiation enable, bit 9 restart, bit 8 full duplex).
- R8: The block then reads register 1 repeatedly, waiting at least POLL_MS milliseconds after each read that shows link down. The first read with bit 2 set finishes with `link_up_o`=1 and `fail_o`=0.
- R9: If LINK_WAIT_MS/POLL_MS link reads all show link down, the block finishes with `link_timeout_o`=1, `link_up_o`=0 and `fail_o`=0.
- R10: Each access holds `mgmt_req_o` high with stable write flag, address, register and write data until `mgmt_ack_i` is seen, with one access outstanding at a time. `mgmt_rdata_i` is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset; rising edge starts the sequence |
| phy_rst_no | output | 1 | Transceiver hardware reset, active low |
| mgmt_req_o | output | 1 | Management access request |
| mgmt_wr_o | output | 1 | 1 = register write, 0 = register read |
| mgmt_phy_o | output | 5 | Management device address |
| mgmt_reg_o | output | 5 | Register number |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_ack_i | input | 1 | One-cycle access completion |
| mgmt_rdata_i | input | 16 | Read data, valid with `mgmt_ack_i` |
| done_o | output | 1 | Sequence finished (sticky until reset) |
| phy_addr_o | output | 5 | Selected device address |
| link_up_o | output | 1 | Link came up |
| fail_o | output | 2 | 0 none, 1 no device, 2 soft reset stuck |
| link_timeout_o | output | 1 | Link wait budget exhausted |

## Verification
The link-wait exhaustion path is the hardest case to reach. It needs a device that is found, is not linked, clears its soft reset inside the retry budget and then never reports link for hundreds of polls. Each of those conditions can only be set from the read data. The bench's transceiver model is scripted with the responding address, the number of reset-bit-set reads and the poll on which link appears, so each terminal branch is reached on purpose. The time scale is divided down so that the full 500-poll timeout fits in a short run, and the gap between link polls is measured in cycles.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    FAIL_NONE   = 2'd0,
    FAIL_NO_PHY = 2'd1,
    FAIL_SRST   = 2'd2
  } fail_e;

  typedef enum logic [3:0] {
    ST_RST_ARM,
    ST_RST_HOLD,
    ST_SCAN,
    ST_SCAN_W,
    ST_STAT,
    ST_STAT_W,
    ST_SRST,
    ST_SRST_W,
    ST_SRST_RD,
    ST_SRST_RD_W,
    ST_AN,
    ST_AN_W,
    ST_LINK,
    ST_LINK_W,
    ST_LINK_GAP,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  localparam logic [4:0]  REG_CTRL      = 5'd0;
  localparam logic [4:0]  REG_STAT      = 5'd1;
  localparam int          CTRL_RST_BIT  = 15;
  localparam int          STAT_LINK_BIT = 2;
  localparam logic [15:0] CTRL_SRST_VAL = 16'h8000;
  localparam logic [15:0] CTRL_AN_VAL   = 16'h1300;

endpackage

// File: rtl/phy_ms_timer.sv
module phy_ms_timer #(
  parameter int TICK_CYCLES = 50000,
  parameter int MS_W        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            fire_o
);

  localparam int CYC_W = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);

  logic [CYC_W-1:0] cyc_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;
  logic             fire_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      ms_q   <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (start_i) begin
        cyc_q <= '0;
        ms_q  <= ms_i;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cyc_q == CYC_W'(TICK_CYCLES - 1)) begin
          cyc_q <= '0;
          if (ms_q <= MS_W'(1)) begin
            run_q  <= 1'b0;
            fire_q <= 1'b1;
          end else begin
            ms_q <= ms_q - MS_W'(1);
          end
        end else begin
          cyc_q <= cyc_q + CYC_W'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;

  // fire is a single pulse; a new window needs a new start
  p_fire_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);

  p_idle_no_fire_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start_i) |=> !fire_q);

endmodule

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
  import phy_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        issue_i,
  input  mgmt_cmd_t   cmd_i,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        req_o,
  output mgmt_cmd_t   cmd_o,
  input  logic        ack_i,
  input  logic [15:0] rdata_i
);

  logic        req_q;
  logic        done_q;
  mgmt_cmd_t   cmd_q;
  logic [15:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!req_q) begin
        if (issue_i) begin
          cmd_q <= cmd_i;
          req_q <= 1'b1;
        end
      end else if (ack_i) begin
        req_q   <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= rdata_i;
      end
    end
  end

  assign req_o   = req_q;
  assign cmd_o   = cmd_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> (req_q && $stable(cmd_q)));

  p_issue_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> !req_q);

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int NUM_ADDR    = 32,
  parameter int RST_HOLD_MS = 15,
  parameter int POLL_MS     = 10,
  parameter int SRST_TRIES  = 10,
  parameter int LINK_POLLS  = 500,
  parameter int MS_W        = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            tmr_start_o,
  output logic [MS_W-1:0] tmr_ms_o,
  input  logic            tmr_fire_i,
  output logic            issue_o,
  output mgmt_cmd_t       cmd_o,
  input  logic            mg_done_i,
  input  logic [15:0]     mg_rdata_i,
  output logic            phy_rst_no,
  output logic            done_o,
  output logic [4:0]      phy_addr_o,
  output logic            link_up_o,
  output fail_e           fail_o,
  output logic            link_timeout_o
);

  localparam int TRY_W  = $clog2(SRST_TRIES + 1);
  localparam int POLL_W = $clog2(LINK_POLLS + 1);

  seq_state_e        state_q, state_d;
  logic [4:0]        addr_q, addr_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              rstn_q, rstn_d;
  logic              done_q, done_d;
  logic              link_q, link_d;
  logic              to_q, to_d;
  fail_e             fail_q, fail_d;

  logic rd_rst_bit, rd_link_bit;
  assign rd_rst_bit  = mg_rdata_i[CTRL_RST_BIT];
  assign rd_link_bit = mg_rdata_i[STAT_LINK_BIT];

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    try_d       = try_q;
    poll_d      = poll_q;
    rstn_d      = rstn_q;
    done_d      = done_q;
    link_d      = link_q;
    to_d        = to_q;
    fail_d      = fail_q;
    tmr_start_o = 1'b0;
    tmr_ms_o    = '0;
    issue_o     = 1'b0;
    cmd_o       = '0;
    cmd_o.phy   = addr_q;
    unique case (state_q)
      ST_RST_ARM: begin
        tmr_start_o = 1'b1;
        tmr_ms_o    = MS_W'(RST_HOLD_MS);
        state_d     = ST_RST_HOLD;
      end
      ST_RST_HOLD: begin
        if (tmr_fire_i) begin
          rstn_d  = 1'b1;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        issue_o    = 1'b1;
        cmd_o.regn = REG_CTRL;
        state_d    = ST_SCAN_W;
      end
      ST_SCAN_W: begin
        if (mg_done_i) begin
          if (!rd_rst_bit) begin
            state_d = ST_STAT;
          end else if (addr_q == 5'(NUM_ADDR - 1)) begin
            fail_d  = FAIL_NO_PHY;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            addr_d  = addr_q + 5'd1;
            state_d = ST_SCAN;
          end
        end
      end
      ST_STAT: begin
        issue_o    = 1'b1;
        cmd_o.regn = REG_STAT;
        state_d    = ST_STAT_W;
      end
      ST_STAT_W: begin
        if (mg_done_i) begin
          if (rd_link_bit) begin
            link_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_SRST;
          end
        end
      end
      ST_SRST: begin
        issue_o     = 1'b1;
        cmd_o.wr    = 1'b1;
        cmd_o.regn  = REG_CTRL;
        cmd_o.wdata = CTRL_SRST_VAL;
        state_d     = ST_SRST_W;
      end
      ST_SRST_W: begin
        if (mg_done_i) begin
          try_d   = '0;
          state_d = ST_SRST_RD;
        end
      end
      ST_SRST_RD: begin
        issue_o    = 1'b1;
        cmd_o.regn = REG_CTRL;
        state_d    = ST_SRST_RD_W;
      end
      ST_SRST_RD_W: begin
        if (mg_done_i) begin
          if (!rd_rst_bit) begin
            state_d = ST_AN;
          end else if (try_q == TRY_W'(SRST_TRIES - 1)) begin
            fail_d  = FAIL_SRST;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            try_d   = try_q + TRY_W'(1);
            state_d = ST_SRST_RD;
          end
        end
      end
      ST_AN: begin
        issue_o     = 1'b1;
        cmd_o.wr    = 1'b1;
        cmd_o.regn  = REG_CTRL;
        cmd_o.wdata = CTRL_AN_VAL;
        state_d     = ST_AN_W;
      end
      ST_AN_W: begin
        if (mg_done_i) begin
          poll_d  = '0;
          state_d = ST_LINK;
        end
      end
      ST_LINK: begin
        issue_o    = 1'b1;
        cmd_o.regn = REG_STAT;
        state_d    = ST_LINK_W;
      end
      ST_LINK_W: begin
        if (mg_done_i) begin
          if (rd_link_bit) begin
            link_d  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else if (poll_q == POLL_W'(LINK_POLLS - 1)) begin
            to_d    = 1'b1;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            poll_d      = poll_q + POLL_W'(1);
            tmr_start_o = 1'b1;
            tmr_ms_o    = MS_W'(POLL_MS);
            state_d     = ST_LINK_GAP;
          end
        end
      end
      ST_LINK_GAP: begin
        if (tmr_fire_i) state_d = ST_LINK;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST_ARM;
      addr_q  <= '0;
      try_q   <= '0;
      poll_q  <= '0;
      rstn_q  <= 1'b0;
      done_q  <= 1'b0;
      link_q  <= 1'b0;
      to_q    <= 1'b0;
      fail_q  <= FAIL_NONE;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      try_q   <= try_d;
      poll_q  <= poll_d;
      rstn_q  <= rstn_d;
      done_q  <= done_d;
      link_q  <= link_d;
      to_q    <= to_d;
      fail_q  <= fail_d;
    end
  end

  assign phy_rst_no     = rstn_q;
  assign done_o         = done_q;
  assign phy_addr_o     = addr_q;
  assign link_up_o      = link_q;
  assign fail_o         = fail_q;
  assign link_timeout_o = to_q;

  p_fail_terminal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q != FAIL_NONE) |-> done_q);

  p_tries_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    try_q < TRY_W'(SRST_TRIES));

  p_link_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_q |-> (done_q && fail_q == FAIL_NONE && !to_q));

  p_timeout_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> (!link_q && fail_q == FAIL_NONE));

  p_done_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> (done_q && $stable(addr_q)));

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_seq_pkg::*;
#(
  parameter int CLK_FREQ_HZ  = 50_000_000,
  parameter int TIME_DIV     = 1,
  parameter int NUM_ADDR     = 32,
  parameter int RST_HOLD_MS  = 15,
  parameter int POLL_MS      = 10,
  parameter int LINK_WAIT_MS = 5000,
  parameter int SRST_TRIES   = 10
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        phy_rst_no,
  output logic        mgmt_req_o,
  output logic        mgmt_wr_o,
  output logic [4:0]  mgmt_phy_o,
  output logic [4:0]  mgmt_reg_o,
  output logic [15:0] mgmt_wdata_o,
  input  logic        mgmt_ack_i,
  input  logic [15:0] mgmt_rdata_i,
  output logic        done_o,
  output logic [4:0]  phy_addr_o,
  output logic        link_up_o,
  output logic [1:0]  fail_o,
  output logic        link_timeout_o
);

  localparam int TICK_RAW    = CLK_FREQ_HZ / 1000 / TIME_DIV;
  localparam int TICK_CYCLES = (TICK_RAW < 1) ? 1 : TICK_RAW;
  localparam int POLLS_RAW   = LINK_WAIT_MS / POLL_MS;
  localparam int LINK_POLLS  = (POLLS_RAW < 1) ? 1 : POLLS_RAW;
  localparam int MS_MAX      = (RST_HOLD_MS > POLL_MS) ? RST_HOLD_MS : POLL_MS;
  localparam int MS_W        = $clog2(MS_MAX + 1);

  logic            tmr_start, tmr_fire;
  logic [MS_W-1:0] tmr_ms;
  logic            issue, mg_done;
  mgmt_cmd_t       cmd_new, cmd_bus;
  logic [15:0]     mg_rdata;
  fail_e           fail;

  phy_ms_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .MS_W       (MS_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tmr_start),
    .ms_i   (tmr_ms),
    .fire_o (tmr_fire)
  );

  phy_mgmt_port u_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .issue_i(issue),
    .cmd_i  (cmd_new),
    .done_o (mg_done),
    .rdata_o(mg_rdata),
    .req_o  (mgmt_req_o),
    .cmd_o  (cmd_bus),
    .ack_i  (mgmt_ack_i),
    .rdata_i(mgmt_rdata_i)
  );

  phy_seq_ctrl #(
    .NUM_ADDR   (NUM_ADDR),
    .RST_HOLD_MS(RST_HOLD_MS),
    .POLL_MS    (POLL_MS),
    .SRST_TRIES (SRST_TRIES),
    .LINK_POLLS (LINK_POLLS),
    .MS_W       (MS_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tmr_start_o   (tmr_start),
    .tmr_ms_o      (tmr_ms),
    .tmr_fire_i    (tmr_fire),
    .issue_o       (issue),
    .cmd_o         (cmd_new),
    .mg_done_i     (mg_done),
    .mg_rdata_i    (mg_rdata),
    .phy_rst_no    (phy_rst_no),
    .done_o        (done_o),
    .phy_addr_o    (phy_addr_o),
    .link_up_o     (link_up_o),
    .fail_o        (fail),
    .link_timeout_o(link_timeout_o)
  );

  assign fail_o       = fail;
  assign mgmt_wr_o    = cmd_bus.wr;
  assign mgmt_phy_o   = cmd_bus.phy;
  assign mgmt_reg_o   = cmd_bus.regn;
  assign mgmt_wdata_o = cmd_bus.wdata;

  p_quiet_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_rst_no |-> !mgmt_req_o);

  p_no_write_on_scan_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && mgmt_wr_o) |-> (mgmt_reg_o == REG_CTRL));

endmodule

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;

  localparam int TICK   = 4;
  localparam int HOLD   = 15;
  localparam int POLLMS = 10;
  localparam int NPOLL  = 500;
  localparam int NTRY   = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phy_rst_no, mgmt_req_o, mgmt_wr_o;
  logic [4:0]  mgmt_phy_o, mgmt_reg_o, phy_addr_o;
  logic [15:0] mgmt_wdata_o;
  logic        mgmt_ack_i = 1'b0;
  logic [15:0] mgmt_rdata_i = '0;
  logic        done_o, link_up_o, link_timeout_o;
  logic [1:0]  fail_o;

  always #10 clk = ~clk;

  phy_bringup_seq #(
    .CLK_FREQ_HZ (50_000_000),
    .TIME_DIV    (12500),
    .NUM_ADDR    (32),
    .RST_HOLD_MS (HOLD),
    .POLL_MS     (POLLMS),
    .LINK_WAIT_MS(5000),
    .SRST_TRIES  (NTRY)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .phy_rst_no(phy_rst_no),
    .mgmt_req_o(mgmt_req_o), .mgmt_wr_o(mgmt_wr_o), .mgmt_phy_o(mgmt_phy_o),
    .mgmt_reg_o(mgmt_reg_o), .mgmt_wdata_o(mgmt_wdata_o),
    .mgmt_ack_i(mgmt_ack_i), .mgmt_rdata_i(mgmt_rdata_i),
    .done_o(done_o), .phy_addr_o(phy_addr_o), .link_up_o(link_up_o),
    .fail_o(fail_o), .link_timeout_o(link_timeout_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit hung = 0;

  // transceiver model configuration
  int cfg_addr = 0;
  bit cfg_link0 = 0;
  int cfg_srst = 0;
  int cfg_link_after = 0;

  // model state
  int m_srst_left = 0;
  bit m_an = 0;
  int m_polls = 0;
  int m_lat = 0;

  logic [26:0] exp_q[$];
  int last_link_cyc = -1;
  int min_gap = 1 << 30;
  bit req_in_rst = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] respond(logic wr, logic [4:0] phy, logic [4:0] rg);
    if (wr) return 16'h0;
    if (rg == 5'd0) begin
      if (int'(phy) != cfg_addr) return 16'hFFFF;
      if (m_srst_left > 0) return 16'h8000;
      return 16'h3100;
    end
    if (cfg_link0) return 16'h7809 | 16'h0004;
    if (m_an && m_polls >= cfg_link_after) return 16'h0004;
    return 16'h7809;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      mgmt_ack_i  <= 1'b0;
      m_lat       <= 0;
      m_srst_left <= 0;
      m_an        <= 1'b0;
      m_polls     <= 0;
    end else if (mgmt_ack_i) begin
      mgmt_ack_i <= 1'b0;
    end else if (mgmt_req_o && m_lat == 2) begin
      mgmt_ack_i   <= 1'b1;
      mgmt_rdata_i <= respond(mgmt_wr_o, mgmt_phy_o, mgmt_reg_o);
      m_lat        <= 0;
      if (!mgmt_wr_o && mgmt_reg_o == 5'd0 && int'(mgmt_phy_o) == cfg_addr && m_srst_left > 0)
        m_srst_left <= m_srst_left - 1;
      if (mgmt_wr_o && mgmt_wdata_o == 16'h8000) m_srst_left <= cfg_srst;
      if (mgmt_wr_o && mgmt_wdata_o == 16'h1300) begin
        m_an    <= 1'b1;
        m_polls <= 0;
      end
      if (!mgmt_wr_o && mgmt_reg_o == 5'd1 && m_an) m_polls <= m_polls + 1;
    end else if (mgmt_req_o) begin
      m_lat <= m_lat + 1;
    end
  end

  // monitor: pop expected access on every acknowledged request
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && !phy_rst_no && mgmt_req_o) req_in_rst = 1;
    if (rst_ni && mgmt_ack_i && mgmt_req_o) begin
      logic [26:0] got;
      got = {mgmt_wr_o, mgmt_phy_o, mgmt_reg_o, mgmt_wdata_o};
      if (exp_q.size() == 0) begin
        check("R10 unexpected access", 32'(got), 32'h7FFFFFF);
      end else begin
        check("R10 access order", 32'(got), 32'(exp_q.pop_front()));
      end
      if (!mgmt_wr_o && mgmt_reg_o == 5'd1 && m_an) begin
        if (last_link_cyc >= 0 && cyc - last_link_cyc < min_gap)
          min_gap = cyc - last_link_cyc;
        last_link_cyc = cyc;
      end
    end
  end

  function automatic logic [26:0] acc(bit wr, int phy, int rg, logic [15:0] d);
    return {wr, 5'(phy), 5'(rg), d};
  endfunction

  task automatic run_scn(string name, int addr, bit link0, int srst, int link_after);
    int exp_fail, n, low;
    bit exp_link, exp_to;
    exp_fail = 0; exp_link = 0; exp_to = 0;
    exp_q.delete();
    last_link_cyc = -1;
    min_gap = 1 << 30;
    req_in_rst = 0;
    // expected access list from the requirements
    for (int a = 0; a < 32 && a <= addr; a++) exp_q.push_back(acc(0, a, 0, 16'h0));
    if (addr > 31) exp_fail = 1;
    else begin
      exp_q.push_back(acc(0, addr, 1, 16'h0));
      if (link0) exp_link = 1;
      else begin
        exp_q.push_back(acc(1, addr, 0, 16'h8000));
        n = srst + 1;
        if (n > NTRY) begin
          for (int i = 0; i < NTRY; i++) exp_q.push_back(acc(0, addr, 0, 16'h0));
          exp_fail = 2;
        end else begin
          for (int i = 0; i < n; i++) exp_q.push_back(acc(0, addr, 0, 16'h0));
          exp_q.push_back(acc(1, addr, 0, 16'h1300));
          n = link_after + 1;
          if (n > NPOLL) begin
            for (int i = 0; i < NPOLL; i++) exp_q.push_back(acc(0, addr, 1, 16'h0));
            exp_to = 1;
          end else begin
            for (int i = 0; i < n; i++) exp_q.push_back(acc(0, addr, 1, 16'h0));
            exp_link = 1;
          end
        end
      end
    end
    cfg_addr = addr; cfg_link0 = link0; cfg_srst = srst; cfg_link_after = link_after;
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check({name, " R1 reset pin low in reset"}, 32'(phy_rst_no), 0);
    check({name, " R1 idle in reset"}, {done_o, mgmt_req_o, link_up_o, fail_o, link_timeout_o}, 0);
    rst_ni = 1'b1;
    low = 0;
    while (!phy_rst_no && low < 1000) begin
      @(negedge clk);
      low++;
    end
    check({name, " R1 hold long enough"}, 32'(low >= HOLD * TICK), 1);
    check({name, " R1 hold not excessive"}, 32'(low <= HOLD * TICK + 4), 1);
    n = 0;
    while (!done_o && n < 40000) begin
      @(negedge clk);
      n++;
    end
    if (!done_o) begin
      hung = 1;
      check({name, " watchdog done"}, 0, 1);
      return;
    end
    repeat (4) @(negedge clk);
    check({name, " R1 no access while reset pin low"}, 32'(req_in_rst), 0);
    check({name, " R10 all expected accesses seen"}, exp_q.size(), 0);
    check({name, " R3 R6 fail code"}, 32'(fail_o), exp_fail);
    check({name, " R4 R8 link flag"}, 32'(link_up_o), 32'(exp_link));
    check({name, " R9 timeout flag"}, 32'(link_timeout_o), 32'(exp_to));
    if (addr <= 31) check({name, " R2 selected address"}, 32'(phy_addr_o), addr);
    check({name, " R10 no request after done"}, 32'(mgmt_req_o), 0);
  endtask

  initial begin
    // R4: device at 3, already linked
    run_scn("A", 3, 1, 0, 0);
    // R3: nothing answers
    if (!hung) run_scn("B", 40, 0, 0, 0);
    // R5 R7 R8: device at 0, reset clears on third read, link on fourth poll
    if (!hung) begin
      run_scn("C", 0, 0, 2, 3);
      check("C R8 poll spacing", 32'(min_gap >= POLLMS * TICK), 1);
    end
    // R2: last address only
    if (!hung) run_scn("D", 31, 1, 0, 0);
    // R6: reset bit never clears
    if (!hung) run_scn("E", 5, 0, 99, 0);
    // R5 boundary: clears on the tenth read
    if (!hung) run_scn("F", 2, 0, 9, 0);
    // R9: link never comes up
    if (!hung) run_scn("G", 7, 0, 0, 100000);
    // R8 boundary: link on the last allowed poll
    if (!hung) run_scn("H", 1, 0, 0, NPOLL - 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule